// File: doc/BRIEF.md
# Host I/O Decoder and Acquisition Control Register

This block is the host-facing I/O interface of a four-channel data acquisition card on an ISA-style I/O bus. It decodes a fixed window of eight even I/O addresses. Each of these addresses serves two purposes. A read returns the latest 12-bit converter sample in a 16-bit word and asks the bus for a 16-bit cycle. An 8-bit write loads a control register that picks the analog input and the amplifier gain.

The bus read and write commands are active low on the bus. Upstream logic inverts them, so they reach this block as active-high strobes. Channel and gain come out as one-hot switch enables for the analog multiplexer and the gain network.

The block also divides the system clock down to the converter clock. Read decode and read data are combinational from the address and the strobe. The control register and the divider are clocked.

Top module: `isa_daq_host_if`

## Requirements
- R1: An address decodes only when it lies in 0x310..0x31E and bit 0 is zero. Odd addresses and addresses outside the window produce no chip select and no 16-bit cycle indication.
- R2: A read strobe at a decoded address asserts the read chip select and the 16-bit cycle indication together, in the same cycle, and neither is asserted otherwise.
- R3: During a decoded read, the data enable is high and the data bus carries `{4'b0000, sample}`, so bits 15:12 are zero.
- R4: When no decoded read is in progress, the data enable is low and the data bus is driven to all zeros.
- R5: A write strobe at a decoded address asserts the write chip select and loads the 8-bit write data into the control register at that clock edge. The new selection is visible on the outputs right after that edge.
- R6: Control bits 1:0 select the gain, and gain_en_o is one-hot with bit index equal to the code: code 0 is x1 (bit 0), 1 is x2 (bit 1), 2 is x5 (bit 2) and 3 is x10 (bit 3).
- R7: Control bits 3:2 select the input, and chan_en_o is one-hot with bit index equal to the code: code 0 is channel 1 (bit 0), 1 is channel 2, 2 is channel 3 and 3 is channel 4.
- R8: Control bits 7:4 are stored but have no effect on chan_en_o or gain_en_o.
- R9: After reset the control register is zero, so chan_en_o = 0001 and gain_en_o = 0001, and the converter clock is low.
- R10: The converter clock has a period of SYS_CLK_HZ/CONV_CLK_HZ system clocks (200 with the defaults, which gives 250 kHz from 50 MHz) and is high for half of that period.
- R11: A write strobe at an odd or out-of-window address leaves the channel and gain selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 10 | I/O address |
| io_rd_i | input | 1 | I/O read strobe, active high |
| io_wr_i | input | 1 | I/O write strobe, active high |
| wr_data_i | input | 8 | Write data (low byte of the bus) |
| sample_i | input | 12 | Latest converter sample |
| rd_data_o | output | 16 | Read data to the bus |
| rd_oe_o | output | 1 | Read data drive enable |
| cs_rd_o | output | 1 | Read chip select |
| cs_wr_o | output | 1 | Write chip select |
| io16_o | output | 1 | 16-bit I/O cycle indication |
| chan_en_o | output | 4 | One-hot input channel enable |
| gain_en_o | output | 4 | One-hot gain enable (x1, x2, x5, x10) |
| conv_clk_o | output | 1 | Converter clock |

## Verification
Chip selects, the 16-bit indication and read data are combinational, so they are due in the same cycle as the address and strobe. The bench drives these at a falling edge and checks them a few nanoseconds later, before any rising edge. Channel and gain outputs change at the single rising edge that samples a write strobe. The bench therefore holds a write for exactly one clock and samples at the next falling edge, which means one clock after the write was driven. The converter clock is measured over several periods by counting falling edges of the system clock between its rising edges, and by counting how many of those sample it high.

// File: rtl/isa_daq_pkg.sv
package isa_daq_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned N_SEL = 1 << SEL_W;

  typedef struct packed {
    logic [3:0]       spare;
    logic [SEL_W-1:0] chan;
    logic [SEL_W-1:0] gain;
  } ctrl_t;

  function automatic int unsigned div_ratio(input int unsigned sys_hz, input int unsigned out_hz);
    return sys_hz / out_hz;
  endfunction
endpackage

// File: rtl/io_win_decode.sv
module io_win_decode #(
  parameter int unsigned ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 10'h310,
  parameter logic [ADDR_W-1:0] WIN_LAST = 10'h31E
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              hit_o,
  output logic              cs_rd_o,
  output logic              cs_wr_o
);
  logic in_range;
  assign in_range = (addr_i >= WIN_BASE) && (addr_i <= WIN_LAST);
  // only even (word aligned) addresses respond
  assign hit_o    = in_range && !addr_i[0];
  assign cs_rd_o  = hit_o && rd_i;
  assign cs_wr_o  = hit_o && wr_i;
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     oh_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign oh_o[i] = (sel_i == i[SEL_W-1:0]);
  end
endmodule

// File: rtl/clk_div.sv
module clk_div #(
  parameter int unsigned DIV = 200,
  localparam int unsigned HALF = DIV / 2,
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/isa_daq_host_if.sv
module isa_daq_host_if
  import isa_daq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 10'h310,
  parameter logic [ADDR_W-1:0] WIN_LAST = 10'h31E,
  parameter int unsigned SMP_W       = 12,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned SYS_CLK_HZ  = 50_000_000,
  parameter int unsigned CONV_CLK_HZ = 250_000,
  localparam int unsigned DIV = div_ratio(SYS_CLK_HZ, CONV_CLK_HZ),
  localparam int unsigned PAD = BUS_W - SMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [SMP_W-1:0]  sample_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              rd_oe_o,
  output logic              cs_rd_o,
  output logic              cs_wr_o,
  output logic              io16_o,
  output logic [N_SEL-1:0]  chan_en_o,
  output logic [N_SEL-1:0]  gain_en_o,
  output logic              conv_clk_o
);
  logic  hit;
  ctrl_t ctrl_q;

  io_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_dec (
    .addr_i (io_addr_i),
    .rd_i   (io_rd_i),
    .wr_i   (io_wr_i),
    .hit_o  (hit),
    .cs_rd_o(cs_rd_o),
    .cs_wr_o(cs_wr_o)
  );

  // 16-bit cycle flagged only for reads; writes are byte wide
  assign io16_o    = cs_rd_o;
  assign rd_oe_o   = cs_rd_o;
  assign rd_data_o = cs_rd_o ? {{PAD{1'b0}}, sample_i} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (cs_wr_o) ctrl_q <= ctrl_t'(wr_data_i);
  end

  onehot_dec #(.SEL_W(SEL_W)) u_chan_dec (.sel_i(ctrl_q.chan), .oh_o(chan_en_o));
  onehot_dec #(.SEL_W(SEL_W)) u_gain_dec (.sel_i(ctrl_q.gain), .oh_o(gain_en_o));

  clk_div #(.DIV(DIV)) u_div (.clk_i(clk_i), .rst_ni(rst_ni), .clk_o(conv_clk_o));

  logic unused_hit;
  assign unused_hit = hit;
endmodule

// File: rtl/isa_daq_host_if_chk.sv
module isa_daq_host_if_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned SMP_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_rd_i,
  input logic              io_wr_i,
  input logic [SMP_W-1:0]  sample_i,
  input logic [BUS_W-1:0]  rd_data_o,
  input logic              rd_oe_o,
  input logic              cs_rd_o,
  input logic              cs_wr_o,
  input logic              io16_o,
  input logic [3:0]        chan_en_o,
  input logic [3:0]        gain_en_o
);
  assert_odd_no_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_addr_i[0] |-> !cs_rd_o && !cs_wr_o && !io16_o);

  assert_rd_io16_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rd_o |-> io16_o && io_rd_i);

  assert_rd_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rd_o |-> rd_oe_o && rd_data_o == {{(BUS_W-SMP_W){1'b0}}, sample_i});

  assert_idle_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rd_o |-> !rd_oe_o && rd_data_o == '0);

  assert_chan_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_en_o) == 1);

  assert_gain_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gain_en_o) == 1);

  assert_hold_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_wr_o |=> $stable(chan_en_o) && $stable(gain_en_o));
endmodule

bind isa_daq_host_if isa_daq_host_if_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .SMP_W(SMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_rd_i(io_rd_i),
  .io_wr_i(io_wr_i), .sample_i(sample_i), .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o),
  .cs_rd_o(cs_rd_o), .cs_wr_o(cs_wr_o), .io16_o(io16_o),
  .chan_en_o(chan_en_o), .gain_en_o(gain_en_o)
);

// File: tb/isa_daq_host_if_tb.sv
`timescale 1ns/1ps
module isa_daq_host_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdat = '0;
  logic [11:0] smp = '0;
  logic [15:0] rdat;
  logic        oe, csr, csw, io16, cclk;
  logic [3:0]  chan, gain;
  int n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  isa_daq_host_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_rd_i(rd), .io_wr_i(wr),
    .wr_data_i(wdat), .sample_i(smp), .rd_data_o(rdat), .rd_oe_o(oe),
    .cs_rd_o(csr), .cs_wr_o(csw), .io16_o(io16), .chan_en_o(chan),
    .gain_en_o(gain), .conv_clk_o(cclk)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdat = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = '0;
  endtask

  task automatic t_reset;
    chk(chan == 4'b0001, "R9 chan", chan, 4'b0001);
    chk(gain == 4'b0001, "R9 gain", gain, 4'b0001);
    chk(cclk == 1'b0, "R9 conv_clk", cclk, 0);
  endtask

  task automatic t_read_window;
    for (int a = 'h310; a <= 'h31E; a += 2) begin
      @(negedge clk); addr = 10'(a); smp = 12'(a * 37 + 12'h5A5); rd = 1'b1;
      #2;
      chk(csr && io16, "R2 cs_rd/io16", {csr, io16}, 2'b11);
      chk(oe && rdat == {4'b0, smp}, "R3 data", rdat, {4'b0, smp});
      chk(!csw, "R1 no cs_wr on read", csw, 0);
    end
    @(negedge clk); rd = 1'b0; smp = 12'hFFF; addr = 10'h310; #2;
    chk(!csr && !io16, "R2 no strobe", {csr, io16}, 0);
    chk(!oe && rdat == 16'h0, "R4 idle bus", rdat, 0);
  endtask

  task automatic t_bad_addr;
    logic [9:0] bad[6] = '{10'h311, 10'h31F, 10'h30E, 10'h320, 10'h010, 10'h315};
    foreach (bad[i]) begin
      @(negedge clk); addr = bad[i]; rd = 1'b1; smp = 12'hABC; #2;
      chk(!csr && !io16 && !csw, "R1 bad addr read", {csr, io16, csw}, 0);
      chk(!oe && rdat == 16'h0, "R4 bad addr bus", rdat, 0);
      rd = 1'b0;
    end
  endtask

  task automatic t_write_modes;
    for (int v = 0; v < 16; v++) begin
      logic [7:0] d;
      d = {4'(15 - v), 4'(v)};
      @(negedge clk); addr = 10'(12'h310 + 2 * (v % 8)); wdat = d; wr = 1'b1; #2;
      chk(csw && !csr && !io16, "R5 cs_wr", {csw, csr, io16}, 3'b100);
      @(negedge clk); wr = 1'b0;
      chk(gain == 4'(1 << d[1:0]), "R6 gain", gain, 4'(1 << d[1:0]));
      chk(chan == 4'(1 << d[3:2]), "R7 chan", chan, 4'(1 << d[3:2]));
    end
  endtask

  task automatic t_spare_bits;
    do_write(10'h31C, 8'h09);
    for (int u = 0; u < 16; u++) begin
      do_write(10'h312, {4'(u), 4'h9});
      chk(chan == 4'b0100 && gain == 4'b0010, "R8 spare bits", {chan, gain}, 8'h42);
    end
  endtask

  task automatic t_write_ignored;
    logic [9:0] bad[4] = '{10'h313, 10'h30E, 10'h320, 10'h31F};
    do_write(10'h318, 8'h0E);
    foreach (bad[i]) begin
      do_write(bad[i], 8'h01);
      chk(chan == 4'b1000 && gain == 4'b0100, "R11 write ignored", {chan, gain}, 8'h84);
    end
  endtask

  task automatic t_conv_clk;
    int cyc = 0, hi = 0, first = -1, last = -1, nrise = 0;
    logic prev;
    prev = cclk;
    while (nrise < 4) begin
      @(negedge clk);
      cyc++;
      if (cclk && !prev) begin
        if (first < 0) first = cyc;
        else begin
          chk(cyc - last == 200, "R10 period", cyc - last, 200);
          chk(hi == 100, "R10 high time", hi, 100);
        end
        last = cyc; nrise++; hi = 0;
      end
      if (cclk) hi++;
      prev = cclk;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #25; t_reset;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); t_reset;
    t_conv_clk;
    t_read_window;
    t_bad_addr;
    t_write_modes;
    t_spare_bits;
    t_write_ignored;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule